// File: doc/BRIEF.md
# Low-pin-count host cycle monitor

This block watches a low-pin-count bus without driving it. On every rising bus-clock edge it samples the four shared nibble lines and the active-low frame strobe. It then follows each host cycle through seven phases: start, type, address, first turnaround, sync, data and second turnaround.

For every I/O or memory single-byte cycle it sees, the block emits one record for a single clock. The record holds:

- the start code and the decoded cycle type;
- the address and the data byte;
- the number of wait clocks spent in sync;
- a five-bit vector of protocol-violation flags.

DMA, bus-master and firmware cycles are recognised from their start or type code. They are then skipped until the next frame. A debug or trace subsystem attaches the block beside the bus and stores the records.

Top module: `lpc_cycle_monitor`

## Requirements
- R1: All inputs are sampled on rising `clk` edges only. While `rst` is high at an edge, the monitor returns to idle and `rec_valid` is low on the following clock.
- R2: Frame may stay low for several clocks, and the start code taken is the nibble on the last low clock. Only start code 0000 (target cycle) continues into decoding. Any other final start code, such as 1111 stop or 0010 grant, produces no record.
- R3: The type nibble is decoded from bits [3:1], and bit 0 is ignored. Codes 000 and 001 are I/O read and write, 010 and 011 are memory read and write. Codes 100 and 101 (DMA) and 110 and 111 (illegal) produce no record. `rec_type` carries bits [3:1].
- R4: The address phase is 4 nibbles for I/O (16-bit address, upper bits of `rec_addr` zero) and 8 nibbles for memory. The most significant nibble comes first.
- R5: Each turnaround lasts two clocks. Any turnaround nibble other than 1111 sets flag bit 1 (`rec_flags[1]`).
- R6: In sync, 0101 (short wait) and 0110 (long wait) keep the monitor in sync and add one to a wait count that saturates at 255. 0000 (ready) moves on to data.
- R7: Sync code 1010 ends the cycle at once, with a record that has flag bit 3 set and data 0x00.
- R8: Any other sync code (including 1001) is reserved for this monitor. It sets flag bit 2, is not counted as a wait, and leaves the monitor in sync.
- R9: The data byte takes two clocks, least significant nibble first.
- R10: A change on the nibble lines between consecutive frame-low clocks of one start phase sets flag bit 0.
- R11: Frame low during the address, turnaround, sync or data phases aborts the cycle. A record with flag bit 4 set and the partial fields is emitted, and that clock's nibble becomes the first start nibble of a new cycle.
- R12: `rec_valid` is a one-clock pulse. For a completed cycle it is high on the clock after the edge that samples the second turnaround nibble, and two pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame strobe |
| lad | input | 4 | Shared address/control/data nibble |
| rec_valid | output | 1 | One-clock record strobe |
| rec_start | output | 4 | Start code of the recorded cycle |
| rec_type | output | 3 | Type nibble bits [3:1] |
| rec_addr | output | ADDR_W | Collected address |
| rec_data | output | DATA_W | Collected data byte |
| rec_waits | output | WAIT_W | Saturating wait-clock count |
| rec_flags | output | 5 | {abort, sync error, reserved sync, bad turnaround, start change} |

## Verification
A wrong phase or nibble counter shows at the ports within one cycle. The record's `rec_valid` pulse then lands on a different clock than the expected one, or never arrives. A missing pulse is caught at the first clock where one was due, and a spurious one at the clock it appears.

A misordered shift or a wrong clear shows as a bad address or data in the very next record. A flag or wait counter that is not cleared between cycles shows in the record after it. The bench checks every clock for either a record that matches exactly or the absence of `rec_valid`.

// File: rtl/lpcmon_pkg.sv
package lpcmon_pkg;

    localparam int NIB_W      = 4;
    localparam int IO_NIBBLES = 4;

    localparam logic [NIB_W-1:0] START_TARGET = 4'b0000;
    localparam logic [NIB_W-1:0] TAR_IDLE     = 4'b1111;
    localparam logic [NIB_W-1:0] SYNC_READY   = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_SHORT   = 4'b0101;
    localparam logic [NIB_W-1:0] SYNC_LONG    = 4'b0110;
    localparam logic [NIB_W-1:0] SYNC_ERR     = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_ADDR, PH_TAR1, PH_SYNC, PH_DATA, PH_TAR2
    } phase_e;

    // Bit 4 down to bit 0
    typedef struct packed {
        logic abort;
        logic sync_err;
        logic sync_rsvd;
        logic tar_bad;
        logic frame_chg;
    } viol_t;

    function automatic logic kind_is_io(input logic [2:0] t);
        return t == 3'b000 || t == 3'b001;
    endfunction

    function automatic logic kind_is_mem(input logic [2:0] t);
        return t == 3'b010 || t == 3'b011;
    endfunction

    function automatic logic sync_is_wait(input logic [NIB_W-1:0] n);
        return n == SYNC_SHORT || n == SYNC_LONG;
    endfunction

    function automatic logic sync_is_rsvd(input logic [NIB_W-1:0] n);
        return !(n == SYNC_READY || n == SYNC_ERR || sync_is_wait(n));
    endfunction

endpackage

// File: rtl/lpcmon_start_capture.sv
module lpcmon_start_capture
    import lpcmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             follow,
    input  logic [NIB_W-1:0] lad,
    output logic [NIB_W-1:0] code,
    output logic             changed
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code    <= '0;
            changed <= 1'b0;
        end else if (load) begin
            code    <= lad;
            changed <= 1'b0;
        end else if (follow) begin
            code    <= lad;
            changed <= changed | (lad != code);
        end
    end

    // R10
    chg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (changed && follow && !load) |=> changed);

endmodule

// File: rtl/lpcmon_sat_counter.sv
module lpcmon_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP && inc && !clr) |=> cnt == TOP);

endmodule

// File: rtl/lpcmon_phase_fsm.sv
module lpcmon_phase_fsm
    import lpcmon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [NIB_W-1:0]  lad,
    input  logic [NIB_W-1:0]  start_code,
    input  logic              start_chg,
    input  logic [WAIT_W-1:0] wait_cnt,
    output logic              cap_load,
    output logic              cap_follow,
    output logic              wait_clr,
    output logic              wait_inc,
    output logic              rec_valid,
    output logic [NIB_W-1:0]  rec_start,
    output logic [2:0]        rec_type,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data,
    output logic [WAIT_W-1:0] rec_waits,
    output viol_t             rec_flags
);

    localparam int MEM_NIBBLES = ADDR_W / NIB_W;
    localparam int NCNT_W      = $clog2(MEM_NIBBLES);
    localparam int DNIBS       = DATA_W / NIB_W;
    localparam int DCNT_W      = (DNIBS > 1) ? $clog2(DNIBS) : 1;

    phase_e              phase;
    logic [NCNT_W-1:0]   nib_left;
    logic [DCNT_W-1:0]   dcnt;
    logic                half;
    logic [2:0]          ctype;
    logic [ADDR_W-1:0]   addr_acc;
    logic [DATA_W-1:0]   data_acc;
    viol_t               flags, viol_now;

    logic frame_low, in_body, abort_now, sync_live, emit_err, emit_done, emit;

    assign frame_low  = ~frame_n;
    assign in_body    = phase inside {PH_ADDR, PH_TAR1, PH_SYNC, PH_DATA, PH_TAR2};
    assign abort_now  = in_body & frame_low;
    assign sync_live  = (phase == PH_SYNC) & ~frame_low;
    assign emit_err   = sync_live & (lad == SYNC_ERR);
    assign emit_done  = (phase == PH_TAR2) & half & ~frame_low;
    assign emit       = abort_now | emit_err | emit_done;
    assign cap_load   = ((phase == PH_IDLE) & frame_low) | abort_now;
    assign cap_follow = (phase == PH_START) & frame_low;
    assign wait_clr   = cap_load;
    assign wait_inc   = sync_live & sync_is_wait(lad);

    always_comb begin
        viol_now           = flags;
        viol_now.frame_chg = start_chg;
        if ((phase == PH_TAR1 || phase == PH_TAR2) && !frame_low && lad != TAR_IDLE)
            viol_now.tar_bad = 1'b1;
        if (emit_err)
            viol_now.sync_err = 1'b1;
        if (sync_live && sync_is_rsvd(lad))
            viol_now.sync_rsvd = 1'b1;
        if (abort_now)
            viol_now.abort = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            nib_left  <= '0;
            dcnt      <= '0;
            half      <= 1'b0;
            ctype     <= '0;
            addr_acc  <= '0;
            data_acc  <= '0;
            flags     <= '0;
            rec_valid <= 1'b0;
            rec_start <= '0;
            rec_type  <= '0;
            rec_addr  <= '0;
            rec_data  <= '0;
            rec_waits <= '0;
            rec_flags <= '0;
        end else begin
            rec_valid <= emit;
            if (emit) begin
                rec_start <= start_code;
                rec_type  <= ctype;
                rec_addr  <= addr_acc;
                rec_data  <= data_acc;
                rec_waits <= wait_cnt;
                rec_flags <= viol_now;
            end
            if (cap_load) begin
                phase    <= PH_START;
                addr_acc <= '0;
                data_acc <= '0;
                flags    <= '0;
                ctype    <= '0;
                half     <= 1'b0;
                dcnt     <= '0;
            end else begin
                flags <= viol_now;
                unique case (phase)
                    PH_IDLE: ;
                    PH_START: begin
                        if (!frame_low) begin
                            if (start_code == START_TARGET && kind_is_io(lad[3:1])) begin
                                ctype    <= lad[3:1];
                                nib_left <= NCNT_W'(IO_NIBBLES - 1);
                                phase    <= PH_ADDR;
                            end else if (start_code == START_TARGET && kind_is_mem(lad[3:1])) begin
                                ctype    <= lad[3:1];
                                nib_left <= NCNT_W'(MEM_NIBBLES - 1);
                                phase    <= PH_ADDR;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_ADDR: begin
                        addr_acc <= {addr_acc[ADDR_W-NIB_W-1:0], lad};
                        if (nib_left == '0) begin
                            phase <= PH_TAR1;
                            half  <= 1'b0;
                        end else begin
                            nib_left <= nib_left - 1'b1;
                        end
                    end
                    PH_TAR1: begin
                        if (half) phase <= PH_SYNC;
                        half <= ~half;
                    end
                    PH_SYNC: begin
                        if (lad == SYNC_READY) begin
                            phase <= PH_DATA;
                            dcnt  <= '0;
                        end else if (lad == SYNC_ERR) begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_DATA: begin
                        data_acc[dcnt*NIB_W +: NIB_W] <= lad;
                        if (dcnt == DCNT_W'(DNIBS - 1)) begin
                            phase <= PH_TAR2;
                            half  <= 1'b0;
                        end else begin
                            dcnt <= dcnt + 1'b1;
                        end
                    end
                    PH_TAR2: begin
                        if (half) phase <= PH_IDLE;
                        half <= ~half;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R12
    rec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid);

    // R6
    ready_to_data_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_live && lad == SYNC_READY) |=> phase == PH_DATA);

    // R7
    err_end_chk: assert property (@(posedge clk) disable iff (rst)
        emit_err |=> (rec_valid && rec_flags.sync_err && phase == PH_IDLE));

    // R11
    abort_restart_chk: assert property (@(posedge clk) disable iff (rst)
        abort_now |=> (phase == PH_START && rec_valid && rec_flags.abort));

    // R5
    tar_len_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TAR1 && half && !frame_low) |=> phase == PH_SYNC);

endmodule

// File: rtl/lpc_cycle_monitor.sv
module lpc_cycle_monitor
    import lpcmon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        lad,
    output logic              rec_valid,
    output logic [3:0]        rec_start,
    output logic [2:0]        rec_type,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data,
    output logic [WAIT_W-1:0] rec_waits,
    output logic [4:0]        rec_flags
);

    logic              cap_load, cap_follow, start_chg, wait_clr, wait_inc;
    logic [NIB_W-1:0]  start_code;
    logic [WAIT_W-1:0] wait_cnt;
    viol_t             flags_s;

    lpcmon_start_capture u_cap (
        .clk(clk), .rst(rst), .load(cap_load), .follow(cap_follow),
        .lad(lad), .code(start_code), .changed(start_chg)
    );

    lpcmon_sat_counter #(.W(WAIT_W)) u_waits (
        .clk(clk), .rst(rst), .clr(wait_clr), .inc(wait_inc), .cnt(wait_cnt)
    );

    lpcmon_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_fsm (
        .clk(clk), .rst(rst), .frame_n(frame_n), .lad(lad),
        .start_code(start_code), .start_chg(start_chg), .wait_cnt(wait_cnt),
        .cap_load(cap_load), .cap_follow(cap_follow),
        .wait_clr(wait_clr), .wait_inc(wait_inc),
        .rec_valid(rec_valid), .rec_start(rec_start), .rec_type(rec_type),
        .rec_addr(rec_addr), .rec_data(rec_data), .rec_waits(rec_waits),
        .rec_flags(flags_s)
    );

    assign rec_flags = flags_s;

endmodule

// File: tb/lpc_cycle_monitor_tb.sv
module lpc_cycle_monitor_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  lad = 4'hF;
    logic        rec_valid;
    logic [3:0]  rec_start;
    logic [2:0]  rec_type;
    logic [31:0] rec_addr;
    logic [7:0]  rec_data;
    logic [7:0]  rec_waits;
    logic [4:0]  rec_flags;

    always #10 clk = ~clk;

    lpc_cycle_monitor u_dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .lad(lad),
        .rec_valid(rec_valid), .rec_start(rec_start), .rec_type(rec_type),
        .rec_addr(rec_addr), .rec_data(rec_data), .rec_waits(rec_waits),
        .rec_flags(rec_flags)
    );

    typedef struct {
        int          idx;
        logic [2:0]  ty;
        logic [31:0] a;
        logic [7:0]  d;
        logic [7:0]  w;
        logic [4:0]  f;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    string cur_tag = "R1";
    int    edge_n = 0;
    int    last_idx = 0;
    int    checks = 0;
    int    fails = 0;
    bit    checking = 1'b0;

    always @(posedge clk) edge_n++;

    always @(negedge clk) begin
        exp_t  e;
        string tg;
        if (checking) begin
            checks++;
            if (expq.size() > 0 && expq[0].idx == edge_n) begin
                e  = expq.pop_front();
                tg = tagq.pop_front();
                if (!rec_valid || rec_start != 4'h0 || rec_type != e.ty || rec_addr != e.a ||
                    rec_data != e.d || rec_waits != e.w || rec_flags != e.f) begin
                    fails++;
                    $display("FAIL %s record@%0d: got v=%0b st=%h ty=%0d a=%h d=%h w=%0d f=%b exp v=1 st=0 ty=%0d a=%h d=%h w=%0d f=%b",
                             tg, edge_n, rec_valid, rec_start, rec_type, rec_addr, rec_data,
                             rec_waits, rec_flags, e.ty, e.a, e.d, e.w, e.f);
                end
            end else if (rec_valid) begin
                fails++;
                $display("FAIL %s/R12 clock %0d: got rec_valid=1 exp 0", cur_tag, edge_n);
            end
        end
    end

    task automatic send(input logic f, input logic [3:0] d);
        @(negedge clk);
        frame_n  = f;
        lad      = d;
        last_idx = edge_n + 1;
    endtask

    task automatic push(input string tag, input int idx, input logic [2:0] ty,
                        input logic [31:0] a, input logic [7:0] d, input logic [7:0] w,
                        input logic [4:0] f);
        exp_t e;
        e.idx = idx; e.ty = ty; e.a = a; e.d = d; e.w = w; e.f = f;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic run_cycle(input string tag, input int nst, input logic [3:0] st0,
                             input logic [3:0] st_last, input logic [3:0] ty,
                             input logic [31:0] addr, input int nrsv, input int nw,
                             input logic [3:0] fin, input logic [7:0] dat,
                             input logic [3:0] t1, input logic [3:0] t2);
        int          nn;
        logic [31:0] ea;
        logic [4:0]  fl;
        int          w;
        cur_tag = tag;
        for (int i = 0; i < nst - 1; i++) send(1'b0, st0);
        send(1'b0, st_last);
        send(1'b1, ty);
        if (st_last != 4'h0 || ty[3:1] >= 3'd4) begin
            for (int i = 0; i < 3; i++) send(1'b1, 4'hF);
            return;
        end
        nn = (ty[3:1] < 3'd2) ? 4 : 8;
        ea = (nn == 4) ? (addr & 32'h0000_FFFF) : addr;
        for (int i = 0; i < nn; i++) send(1'b1, 4'((addr >> (4 * (nn - 1 - i))) & 32'hF));
        send(1'b1, 4'hF);
        send(1'b1, t1);
        for (int i = 0; i < nrsv; i++) send(1'b1, 4'b0011);
        for (int i = 0; i < nw; i++) send(1'b1, (i % 2) ? 4'b0110 : 4'b0101);
        send(1'b1, fin);
        w  = (nw > 255) ? 255 : nw;
        fl = 5'b0;
        fl[0] = (nst > 1) && (st0 != st_last);
        fl[1] = (t1 != 4'hF);
        fl[2] = (nrsv > 0);
        if (fin == 4'b1010) begin
            fl[3] = 1'b1;
            push(tag, last_idx, ty[3:1], ea, 8'h00, 8'(w), fl);
            send(1'b1, 4'hF);
            return;
        end
        send(1'b1, dat[3:0]);
        send(1'b1, dat[7:4]);
        send(1'b1, t2);
        send(1'b1, 4'hF);
        fl[1] = fl[1] | (t2 != 4'hF);
        push(tag, last_idx, ty[3:1], ea, dat, 8'(w), fl);
        send(1'b1, 4'hF);
    endtask

    task automatic run_abort(input string tag, input logic [3:0] ty,
                             input logic [31:0] addr, input int k);
        logic [31:0] acc;
        int          nn;
        cur_tag = tag;
        nn  = (ty[3:1] < 3'd2) ? 4 : 8;
        acc = 32'h0;
        send(1'b0, 4'h0);
        send(1'b1, ty);
        for (int i = 0; i < k; i++) begin
            send(1'b1, 4'((addr >> (4 * (nn - 1 - i))) & 32'hF));
            acc = (acc << 4) | ((addr >> (4 * (nn - 1 - i))) & 32'hF);
        end
        push(tag, last_idx + 1, ty[3:1], acc, 8'h00, 8'h00, 5'b10000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rec_valid !== 1'b0 || rec_flags !== 5'b0) begin
            fails++;
            $display("FAIL R1 reset: got v=%b f=%b exp v=0 f=00000", rec_valid, rec_flags);
        end
        checking = 1'b1;
        run_cycle("R4", 1, 4'h0, 4'h0, 4'b0000, 32'h0000_1234, 0, 0, 4'h0, 8'h5A, 4'hF, 4'hF);
        run_cycle("R9", 1, 4'h0, 4'h0, 4'b0111, 32'hDEAD_BEEF, 0, 0, 4'h0, 8'hC3, 4'hF, 4'hF);
        run_cycle("R10", 3, 4'hF, 4'h0, 4'b0010, 32'h0000_ABCD, 0, 0, 4'h0, 8'h81, 4'hF, 4'hF);
        run_cycle("R2", 2, 4'h0, 4'hF, 4'b0000, 32'h0, 0, 0, 4'h0, 8'h00, 4'hF, 4'hF);
        run_cycle("R2", 1, 4'h0, 4'b0010, 4'b0100, 32'h0, 0, 0, 4'h0, 8'h00, 4'hF, 4'hF);
        run_cycle("R3", 1, 4'h0, 4'h0, 4'b1000, 32'h0, 0, 0, 4'h0, 8'h00, 4'hF, 4'hF);
        run_cycle("R3", 1, 4'h0, 4'h0, 4'b1101, 32'h0, 0, 0, 4'h0, 8'h00, 4'hF, 4'hF);
        run_cycle("R3", 1, 4'h0, 4'h0, 4'b0101, 32'h1020_3040, 0, 0, 4'h0, 8'h77, 4'hF, 4'hF);
        run_cycle("R6", 1, 4'h0, 4'h0, 4'b0001, 32'h0000_0060, 0, 3, 4'h0, 8'h12, 4'hF, 4'hF);
        run_cycle("R6", 1, 4'h0, 4'h0, 4'b0100, 32'h0F00_0001, 0, 260, 4'h0, 8'hE4, 4'hF, 4'hF);
        run_cycle("R7", 1, 4'h0, 4'h0, 4'b0000, 32'h0000_0080, 0, 2, 4'b1010, 8'h00, 4'hF, 4'hF);
        run_cycle("R8", 1, 4'h0, 4'h0, 4'b0010, 32'h0000_4455, 2, 1, 4'h0, 8'h3C, 4'hF, 4'hF);
        run_cycle("R5", 1, 4'h0, 4'h0, 4'b0000, 32'h0000_0101, 0, 0, 4'h0, 8'h99, 4'h0, 4'hF);
        run_cycle("R5", 1, 4'h0, 4'h0, 4'b0110, 32'h8000_0000, 0, 0, 4'h0, 8'h66, 4'hF, 4'h7);
        run_abort("R11", 4'b0110, 32'hCAFE_F00D, 3);
        run_cycle("R11", 1, 4'h0, 4'h0, 4'b0000, 32'h0000_2468, 0, 0, 4'h0, 8'hB5, 4'hF, 4'hF);
        run_cycle("R12", 1, 4'h0, 4'h0, 4'b0011, 32'h0000_0007, 0, 1, 4'h0, 8'h01, 4'hF, 4'hF);
        cur_tag = "R12";
        for (int i = 0; i < 4; i++) send(1'b1, 4'hF);
        @(negedge clk);
        checking = 1'b0;
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R12 missing records: got %0d pending exp 0", expq.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule